// File: doc/BRIEF.md
# Scroll and VRAM Address Register Unit

This block keeps the scroll state of a tile-based video processor. It holds a 15-bit buffered address (`t`), a 15-bit live address (`v`) that feeds the tile fetch pipeline, a 3-bit fine horizontal scroll, and one write-phase flag shared by the scroll port and the address port. The host processor reaches it through register writes and a status-read strobe. The line timing generator supplies a strobe at dot 257 of each rendering line.

Most writes land only in `t`, so they change nothing on screen at once. The fine horizontal scroll is the exception and changes at once. The live address picks up new values at two points only. The dot-257 strobe copies the horizontal part of `t` into it. The second write to the address port copies the whole of `t` into it. Field layout of both addresses: bits 14:12 fine Y, bits 11:10 nametable select, bits 9:5 coarse Y, bits 4:0 coarse X.

Top module: `scroll_addr_unit`

## Requirements
- R1: While `rst` is high and after it is released, `vaddr`, `fine_x`, the buffered address and the write-phase flag are all zero.
- R2: A write with `wr_sel`=0 (control) loads buffered bits 11:10 from `wr_data[1:0]`. It leaves `vaddr`, `fine_x` and the write-phase flag unchanged.
- R3: A write with `wr_sel`=1 (scroll) while the flag is 0 sets `fine_x` to `wr_data[2:0]` on the next cycle. It also loads buffered bits 4:0 from `wr_data[7:3]`.
- R4: A scroll write while the flag is 1 loads buffered bits 14:12 from `wr_data[2:0]` and buffered bits 9:5 from `wr_data[7:3]`.
- R5: A write with `wr_sel`=2 (address) while the flag is 0 loads buffered bits 13:8 from `wr_data[5:0]` and clears buffered bit 14.
- R6: An address write while the flag is 1 loads buffered bits 7:0 from `wr_data`. On the next cycle `vaddr` equals the whole updated buffered address.
- R7: With `render_en` high, a `hcopy` pulse copies buffered bits 4:0 and bit 10 into `vaddr` and keeps the other bits of `vaddr`. The bits copied are the buffered values from before any write in the same cycle.
- R8: With `render_en` low, `hcopy` leaves `vaddr` unchanged.
- R9: Each scroll or address write inverts the shared flag, and a `stat_rd` pulse clears it.
- R10: A write with `wr_sel`=3 changes no state.
- R11: When the second address write and an enabled `hcopy` fall in the same cycle, the full copy of R6 takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 scroll, 2 address, 3 unused |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status-read strobe, clears the write-phase flag |
| render_en | input | 1 | Rendering enabled |
| hcopy | input | 1 | Dot-257 horizontal copy strobe |
| vaddr | output | 15 | Live VRAM address to the fetch pipeline |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The properties assume that a status read never arrives in the same cycle as a register write. The design defines no ordering between the two. The stimulus, both directed and pseudo-random, drops the write whenever it raises `stat_rd`. The stimulus also crosses `hcopy` with address and scroll writes in the same cycle. This checks which source wins and that the copy uses the buffered value from before the write. A behavioural model tracks the flag and both addresses, and the bench checks `vaddr` and `fine_x` against it on every clock.

// File: rtl/sau_pkg.sv
package sau_pkg;

    localparam int DATA_W  = 8;
    localparam int FX_W    = 3;
    localparam int FY_W    = 3;
    localparam int NT_W    = 2;
    localparam int CRS_W   = 5;
    localparam int ADDR_W  = FY_W + NT_W + 2 * CRS_W;

    typedef struct packed {
        logic [FY_W-1:0]  fine_y;
        logic [NT_W-1:0]  nt;
        logic [CRS_W-1:0] coarse_y;
        logic [CRS_W-1:0] coarse_x;
    } vram_addr_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_SCROLL = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ctrl_wr;
        logic scr_first;
        logic scr_second;
        logic adr_first;
        logic adr_second;
    } wr_evt_t;

    function automatic vram_addr_t hcopy_merge(vram_addr_t cur, vram_addr_t src);
        vram_addr_t r;
        r          = cur;
        r.coarse_x = src.coarse_x;
        r.nt[0]    = src.nt[0];
        return r;
    endfunction

endpackage

// File: rtl/sau_decode.sv
module sau_decode
    import sau_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic        stat_rd,
    output wr_evt_t     evt,
    output logic        tog
);
    reg_sel_e sel;
    logic     flips;

    assign sel = reg_sel_e'(wr_sel);

    always_comb begin
        evt = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL:   evt.ctrl_wr = 1'b1;
                SEL_SCROLL: begin
                    evt.scr_first  = ~tog;
                    evt.scr_second =  tog;
                end
                SEL_ADDR: begin
                    evt.adr_first  = ~tog;
                    evt.adr_second =  tog;
                end
                default: ;
            endcase
        end
    end

    assign flips = evt.scr_first | evt.scr_second | evt.adr_first | evt.adr_second;

    always_ff @(posedge clk) begin
        if (rst)
            tog <= 1'b0;
        else if (stat_rd)
            tog <= 1'b0;
        else if (flips)
            tog <= ~tog;
    end
endmodule

// File: rtl/sau_tmp_reg.sv
module sau_tmp_reg
    import sau_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_evt_t            evt,
    input  logic [DATA_W-1:0]  wr_data,
    output vram_addr_t         t_q,
    output logic [FX_W-1:0]    fx_q
);
    localparam int HI_W = ADDR_W - DATA_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q  <= '0;
            fx_q <= '0;
        end else begin
            if (evt.ctrl_wr)
                t_q.nt <= wr_data[NT_W-1:0];
            if (evt.scr_first) begin
                fx_q       <= wr_data[FX_W-1:0];
                t_q.coarse_x <= wr_data[DATA_W-1:FX_W];
            end
            if (evt.scr_second) begin
                t_q.fine_y   <= wr_data[FY_W-1:0];
                t_q.coarse_y <= wr_data[DATA_W-1:FY_W];
            end
            if (evt.adr_first)
                t_q <= {1'b0, wr_data[HI_W-1:0], t_q[DATA_W-1:0]};
            if (evt.adr_second)
                t_q <= {t_q[ADDR_W-1:DATA_W], wr_data};
        end
    end
endmodule

// File: rtl/sau_cur_reg.sv
module sau_cur_reg
    import sau_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_evt_t            evt,
    input  logic [DATA_W-1:0]  wr_data,
    input  vram_addr_t         t_q,
    input  logic               hcopy_go,
    output vram_addr_t         v_q
);
    always_ff @(posedge clk) begin
        if (rst)
            v_q <= '0;
        else if (evt.adr_second)
            v_q <= {t_q[ADDR_W-1:DATA_W], wr_data};
        else if (hcopy_go)
            v_q <= hcopy_merge(v_q, t_q);
    end
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
    import sau_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        stat_rd,
    input  logic        render_en,
    input  logic        hcopy,
    output logic [14:0] vaddr,
    output logic [2:0]  fine_x
);
    wr_evt_t    evt;
    logic       tog;
    vram_addr_t t_q;
    vram_addr_t v_q;
    logic       hcopy_go;

    assign hcopy_go = hcopy & render_en;

    sau_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .stat_rd (stat_rd),
        .evt     (evt),
        .tog     (tog)
    );

    sau_tmp_reg u_tmp (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .wr_data (wr_data),
        .t_q     (t_q),
        .fx_q    (fine_x)
    );

    sau_cur_reg u_cur (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .wr_data  (wr_data),
        .t_q      (t_q),
        .hcopy_go (hcopy_go),
        .v_q      (v_q)
    );

    assign vaddr = v_q;
endmodule

// File: rtl/sau_checker.sv
module sau_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [7:0]  wr_data,
    input logic        stat_rd,
    input logic        render_en,
    input logic        hcopy,
    input logic [14:0] vaddr,
    input logic [2:0]  fine_x,
    input logic        tog
);
    // R1: reset holds outputs at zero
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (vaddr == 15'd0 && fine_x == 3'd0 && !tog));

    // R2: control write has no visible effect
    a_r2_ctrl_invisible: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && !(hcopy && render_en)) |=> ($stable(vaddr) && $stable(fine_x)));

    // R3: fine X follows first scroll write immediately
    a_r3_fine_x_now: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && !tog) |=> (fine_x == $past(wr_data[2:0])));

    // R3: fine X changes only on a first scroll write
    a_r3_fine_x_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 2'd1 && !tog) |=> $stable(fine_x));

    // R6: second address write lands the low byte in vaddr
    a_r6_full_copy_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && tog) |=> (vaddr[7:0] == $past(wr_data)));

    // R8: disabled copy strobe leaves vaddr alone
    a_r8_copy_gated: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_sel == 2'd2 && tog) && !(hcopy && render_en)) |=> $stable(vaddr));

    // R9: status read clears the write-phase flag
    a_r9_stat_clears: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> !tog);

    // R10: unused select leaves flag as is
    a_r10_none_sel: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3 && !stat_rd) |=> $stable(tog));
endmodule

bind scroll_addr_unit sau_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .stat_rd   (stat_rd),
    .render_en (render_en),
    .hcopy     (hcopy),
    .vaddr     (vaddr),
    .fine_x    (fine_x),
    .tog       (tog)
);

// File: tb/sim_scroll_addr_unit.sv
module sim_scroll_addr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        stat_rd = 1'b0;
    logic        render_en = 1'b0;
    logic        hcopy = 1'b0;
    logic [14:0] vaddr;
    logic [2:0]  fine_x;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 0;
    string phase    = "R1";

    logic [14:0] mt, mv, old_t;
    logic [2:0]  mfx;
    bit          mtog, full;

    always #(CLK_PERIOD/2) clk = ~clk;

    scroll_addr_unit u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .stat_rd(stat_rd), .render_en(render_en), .hcopy(hcopy),
        .vaddr(vaddr), .fine_x(fine_x)
    );

    // behavioural reference
    always @(posedge clk) begin
        if (rst) begin
            mt = 0; mv = 0; mfx = 0; mtog = 0;
        end else begin
            old_t = mt;
            full  = 0;
            if (stat_rd) mtog = 0;
            else if (wr_en) begin
                if (wr_sel == 0) mt[11:10] = wr_data[1:0];
                else if (wr_sel == 1) begin
                    if (!mtog) begin mfx = wr_data[2:0]; mt[4:0] = wr_data[7:3]; end
                    else begin mt[14:12] = wr_data[2:0]; mt[9:5] = wr_data[7:3]; end
                    mtog = !mtog;
                end else if (wr_sel == 2) begin
                    if (!mtog) begin mt[13:8] = wr_data[5:0]; mt[14] = 0; end
                    else begin mt[7:0] = wr_data; mv = mt; full = 1; end
                    mtog = !mtog;
                end
            end
            if (hcopy && render_en && !full) begin
                mv[4:0] = old_t[4:0];
                mv[10]  = old_t[10];
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            n_checks++;
            if (vaddr !== mv || fine_x !== mfx) begin
                n_fail++;
                $display("FAIL %s: vaddr=%h fine_x=%0d expected vaddr=%h fine_x=%0d",
                         phase, vaddr, fine_x, mv, mfx);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic idle();
        @(negedge clk);
        wr_en = 0; stat_rd = 0; hcopy = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d; stat_rd = 0; hcopy = 0;
    endtask

    task automatic wr_hc(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d; stat_rd = 0; hcopy = 1;
    endtask

    task automatic hc();
        @(negedge clk);
        wr_en = 0; stat_rd = 0; hcopy = 1;
    endtask

    task automatic srd();
        @(negedge clk);
        wr_en = 0; stat_rd = 1; hcopy = 0;
    endtask

    task automatic expect_v(input string req, input logic [14:0] e);
        @(negedge clk);
        wr_en = 0; stat_rd = 0; hcopy = 0;
        #1;
        n_checks++;
        if (vaddr !== e) begin
            n_fail++;
            $display("FAIL %s: vaddr=%h expected %h", req, vaddr, e);
        end
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        repeat (3) @(negedge clk);
        phase = "R1";
        n_checks++;
        if (vaddr !== 0 || fine_x !== 0) begin
            n_fail++;
            $display("FAIL R1: vaddr=%h fine_x=%0d expected 0 0", vaddr, fine_x);
        end
        rst = 0;
        idle();

        // R5/R6: address pair sets vaddr = 0x3F5A with bit 14 cleared
        phase = "R6";
        wr(2, 8'hFF); wr(2, 8'h5A); expect_v("R6", 15'h3F5A);

        // R2: control write invisible until copy
        phase = "R2";
        wr(0, 8'h03); idle(); expect_v("R2", 15'h3F5A);

        // R3/R4: scroll pair
        phase = "R3";
        wr(1, 8'hAD); idle();
        n_checks++;
        if (fine_x !== 3'd5) begin n_fail++; $display("FAIL R3: fine_x=%0d expected 5", fine_x); end
        phase = "R4";
        wr(1, 8'h7B); idle();

        // R8: disabled copy
        phase = "R8";
        render_en = 0; hc(); expect_v("R8", 15'h3F5A);

        // R7: enabled copy: t = fine_y 3, nt 3, coarse_y 0x0F, coarse_x 0x15
        phase = "R7";
        render_en = 1; hc(); expect_v("R7", {5'b01111, 5'h1A, 5'h15});

        // R9: status read resets phase, next scroll write is first
        phase = "R9";
        wr(1, 8'h01); srd(); wr(1, 8'h02); idle();
        n_checks++;
        if (fine_x !== 3'd2) begin n_fail++; $display("FAIL R9: fine_x=%0d expected 2", fine_x); end
        srd();

        // R10: unused select then address pair unaffected
        phase = "R10";
        wr(3, 8'h12); wr(2, 8'h01); wr(3, 8'h34); wr(2, 8'h23); expect_v("R10", 15'h0123);

        // R11: second address write alongside copy strobe
        phase = "R11";
        wr(2, 8'h2A); wr_hc(2, 8'hC3); expect_v("R11", 15'h2AC3);

        // R7: copy alongside scroll write uses old t
        phase = "R7";
        wr_hc(1, 8'hF8); idle();

        // pseudo-random mix
        phase = "R9";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            stat_rd   = (lfsr[3:0] == 4'd0);
            wr_en     = !stat_rd && lfsr[4];
            wr_sel    = lfsr[6:5];
            wr_data   = lfsr[15:8];
            hcopy     = lfsr[7] & lfsr[2];
            render_en = lfsr[11] | lfsr[1];
        end
        idle(); idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule